// File: doc/BRIEF.md
# Timer and Watchdog with Shared Prescaler

This block combines an 8-bit event timer and a watchdog, with a single 8-bit prescaler between them. A level input decides the owner of the prescaler. When the timer owns it, a 3-bit ratio code divides the timer's count source by 2^(code+1), from 1:2 up to 1:256. When the watchdog owns it, the same division stretches the watchdog period, and the timer then advances once per source event.

The timer counts one of two sources. The first is cycles in which the instruction-cycle enable is high. The second is the chosen edge (rising or falling) of an external pin, which first passes through a two-flop synchronizer and a small edge state machine with states EU_LOW and EU_HIGH. When the timer rolls over from all ones to zero, it sets a sticky overflow request.

The watchdog has a base counter of configurable width and a state machine with three states. WD_OFF moves to WD_RUN when the enable is high. WD_RUN moves to WD_FIRE on expiry and back to WD_OFF when the enable drops. WD_FIRE lasts one cycle and returns to WD_RUN, or to WD_OFF if the enable has dropped. The reset request output is high exactly while the machine is in WD_FIRE.

The control fields arrive as levels from a register held elsewhere. Timer writes, flag clear, watchdog clear and sleep arrive as one-cycle strobes.

Top module: `tmr_wdt_core`

## Requirements
- R1: During and straight after reset, the timer value is 0x00, the overflow flag is 0 and the watchdog request is 0.
- R2: With `psc_to_wdt`=0 and ratio code n on `psc_ratio`, the timer advances once per 2^(n+1) source events, counted from the last prescaler clear.
- R3: With `psc_to_wdt`=1, the timer advances by one in the cycle after each source event (1:1).
- R4: With `src_ext`=0, the source event is a cycle in which `icyc_en`=1. With `src_ext`=1, `icyc_en` is ignored and the source event is a rising edge of `ext_pin` (`edge_fall`=0) or a falling edge (`edge_fall`=1). Such an edge advances the timer at the third rising clock edge after the pin changes.
- R5: A write strobe loads `tmr_wdata` into the timer on the next edge and clears the prescaler. A write takes priority over a count in the same cycle.
- R6: A count from 0xFF to 0x00 sets the overflow flag. The flag stays set until `ovf_clr`. If a new overflow and `ovf_clr` happen in the same cycle, the flag ends up set.
- R7: While the timer owns the prescaler, `sleep_stb` leaves the prescaler untouched.
- R8: While enabled, the watchdog raises a one-cycle request every 2^WDT_BASE_W cycles when it does not own the prescaler. When it owns the prescaler with ratio n, the request comes every 2^(WDT_BASE_W+n+1) cycles.
- R9: `wdt_clr` or `sleep_stb` restarts the watchdog base count, and also clears the prescaler when the watchdog owns it. The next request then comes exactly one full period after the strobe's clock edge, and never in the cycle right after the strobe.
- R10: While `wdt_en`=0 (and in the cycle after it falls), no watchdog request is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| icyc_en | input | 1 | Instruction-cycle enable, internal count source |
| ext_pin | input | 1 | Asynchronous external count pin |
| src_ext | input | 1 | 1 = count external edges, 0 = count instruction cycles |
| edge_fall | input | 1 | 1 = falling edges counted, 0 = rising |
| psc_to_wdt | input | 1 | Prescaler owner: 1 = watchdog, 0 = timer |
| psc_ratio | input | 3 | Ratio code n, divide by 2^(n+1) |
| wdt_en | input | 1 | Watchdog enable |
| tmr_wr | input | 1 | Timer write strobe |
| tmr_wdata | input | 8 | Timer write data |
| ovf_clr | input | 1 | Overflow flag clear strobe |
| wdt_clr | input | 1 | Watchdog clear strobe |
| sleep_stb | input | 1 | Sleep instruction strobe |
| tmr_value | output | 8 | Current timer value |
| ovf_flag | output | 1 | Sticky overflow request |
| wdt_timeout | output | 1 | One-cycle watchdog reset request |

## Verification
Internal state is observed through the ports:
- A prescaler that holds a stale value after a clear shows up within a few source events as a timer count one step early or late. The bench checks counts just below and at each division boundary.
- A watchdog base or prescaler that survives a clear moves the next request away from exactly one period after the strobe, or lets a request through a train of clears spaced inside the period. Either is visible within two periods.
- A wrong edge-state encoding or synchronizer depth gives extra or missing counts, which show up eight cycles after each pin change.

// File: rtl/tw_pkg.sv
package tw_pkg;

    typedef enum logic [1:0] {
        WD_OFF  = 2'd0,
        WD_RUN  = 2'd1,
        WD_FIRE = 2'd2
    } wd_state_e;

    typedef enum logic {
        EU_LOW  = 1'b0,
        EU_HIGH = 1'b1
    } eu_state_e;

endpackage

// File: rtl/tw_edge_unit.sv
module tw_edge_unit #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_in,
    input  logic fall_sel,
    output logic edge_hit
);
    import tw_pkg::*;

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   level;
    eu_state_e              state_q, state_d;

    // synchronizer chain, one flop per stage
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
        if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q[0] <= 1'b0;
                else        sync_q[0] <= pin_in;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q[i] <= 1'b0;
                else        sync_q[i] <= sync_q[i-1];
            end
        end
    end

    assign level = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= EU_LOW;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            EU_LOW:  if (level)  state_d = EU_HIGH;
            EU_HIGH: if (!level) state_d = EU_LOW;
        endcase
    end

    // one-cycle hit on the selected transition
    always_comb begin
        edge_hit = 1'b0;
        unique case (state_q)
            EU_LOW:  edge_hit = level & ~fall_sel;
            EU_HIGH: edge_hit = ~level & fall_sel;
        endcase
    end

endmodule

// File: rtl/tw_prescaler.sv
module tw_prescaler #(
    parameter int CNT_W = 8,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             clr,
    input  logic [SEL_W-1:0] ratio,
    output logic             tap_hit
);
    localparam int NTAP = 1 << SEL_W;

    logic [CNT_W-1:0] cnt_q;
    logic [NTAP-1:0]  full;

    // tap t is ready when the low t+1 bits are all ones
    for (genvar t = 0; t < NTAP; t++) begin : g_tap
        assign full[t] = &cnt_q[t:0];
    end

    assign tap_hit = tick & ~clr & full[ratio];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt_q <= '0;
        else if (clr)  cnt_q <= '0;
        else if (tick) cnt_q <= cnt_q + 1'b1;
    end

endmodule

// File: rtl/tw_timer.sv
module tw_timer #(
    parameter int TMR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             wr,
    input  logic [TMR_W-1:0] wdata,
    input  logic             ovf_clr,
    output logic [TMR_W-1:0] value,
    output logic             ovf
);
    localparam logic [TMR_W-1:0] TOP = '1;

    logic [TMR_W-1:0] value_q;
    logic             ovf_q;
    logic             wrap;

    assign wrap = inc & ~wr & (value_q == TOP);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   value_q <= '0;
        else if (wr)  value_q <= wdata;
        else if (inc) value_q <= value_q + 1'b1;
    end

    // set beats clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ovf_q <= 1'b0;
        else if (wrap)    ovf_q <= 1'b1;
        else if (ovf_clr) ovf_q <= 1'b0;
    end

    assign value = value_q;
    assign ovf   = ovf_q;

endmodule

// File: rtl/tw_watchdog.sv
module tw_watchdog #(
    parameter int BASE_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic restart,
    input  logic use_psc,
    input  logic psc_tap,
    output logic base_tick,
    output logic timeout
);
    import tw_pkg::*;

    wd_state_e         state_q, state_d;
    logic [BASE_W-1:0] base_q;
    logic              running;
    logic              expire;

    assign running   = (state_q != WD_OFF);
    assign base_tick = running & ~restart & (&base_q);
    assign expire    = use_psc ? psc_tap : base_tick;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  base_q <= '0;
        else if (!running || restart) base_q <= '0;
        else                         base_q <= base_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= WD_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WD_OFF:  if (en) state_d = WD_RUN;
            WD_RUN: begin
                if (!en)         state_d = WD_OFF;
                else if (expire) state_d = WD_FIRE;
            end
            WD_FIRE: begin
                if (!en)         state_d = WD_OFF;
                else if (expire) state_d = WD_FIRE;
                else             state_d = WD_RUN;
            end
            default:             state_d = WD_OFF;
        endcase
    end

    always_comb begin
        timeout = 1'b0;
        unique case (state_q)
            WD_FIRE: timeout = 1'b1;
            default: timeout = 1'b0;
        endcase
    end

endmodule

// File: rtl/tmr_wdt_core.sv
module tmr_wdt_core #(
    parameter int TMR_W       = 8,
    parameter int PSC_W       = 8,
    parameter int SEL_W       = 3,
    parameter int WDT_BASE_W  = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             icyc_en,
    input  logic             ext_pin,
    input  logic             src_ext,
    input  logic             edge_fall,
    input  logic             psc_to_wdt,
    input  logic [SEL_W-1:0] psc_ratio,
    input  logic             wdt_en,
    input  logic             tmr_wr,
    input  logic [TMR_W-1:0] tmr_wdata,
    input  logic             ovf_clr,
    input  logic             wdt_clr,
    input  logic             sleep_stb,
    output logic [TMR_W-1:0] tmr_value,
    output logic             ovf_flag,
    output logic             wdt_timeout
);
    logic edge_hit;
    logic src_tick;
    logic psc_tick;
    logic psc_clr;
    logic psc_tap;
    logic tmr_inc;
    logic wd_restart;
    logic wd_base_tick;

    tw_edge_unit #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_in   (ext_pin),
        .fall_sel (edge_fall),
        .edge_hit (edge_hit)
    );

    // source and ownership routing
    assign src_tick   = src_ext ? edge_hit : icyc_en;
    assign psc_tick   = psc_to_wdt ? wd_base_tick : src_tick;
    assign psc_clr    = tmr_wr | (psc_to_wdt & (wdt_clr | sleep_stb));
    assign tmr_inc    = psc_to_wdt ? src_tick : psc_tap;
    assign wd_restart = wdt_clr | sleep_stb;

    tw_prescaler #(.CNT_W(PSC_W), .SEL_W(SEL_W)) u_psc (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (psc_tick),
        .clr     (psc_clr),
        .ratio   (psc_ratio),
        .tap_hit (psc_tap)
    );

    tw_timer #(.TMR_W(TMR_W)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc     (tmr_inc),
        .wr      (tmr_wr),
        .wdata   (tmr_wdata),
        .ovf_clr (ovf_clr),
        .value   (tmr_value),
        .ovf     (ovf_flag)
    );

    tw_watchdog #(.BASE_W(WDT_BASE_W)) u_wdt (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (wdt_en),
        .restart   (wd_restart),
        .use_psc   (psc_to_wdt),
        .psc_tap   (psc_tap),
        .base_tick (wd_base_tick),
        .timeout   (wdt_timeout)
    );

endmodule

// File: rtl/tw_checker.sv
module tw_checker #(
    parameter int TMR_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             icyc_en,
    input logic             src_ext,
    input logic             psc_to_wdt,
    input logic             wdt_en,
    input logic             tmr_wr,
    input logic [TMR_W-1:0] tmr_wdata,
    input logic             ovf_clr,
    input logic             wdt_clr,
    input logic             sleep_stb,
    input logic [TMR_W-1:0] tmr_value,
    input logic             ovf_flag,
    input logic             wdt_timeout
);
    localparam logic [TMR_W-1:0] ONE  = 1;
    localparam logic [TMR_W-1:0] TOPV = '1;
    localparam logic [TMR_W-1:0] ZRO  = '0;

    p_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_wr |=> (tmr_value == $past(tmr_wdata)));

    p_direct_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!src_ext && psc_to_wdt && icyc_en && !tmr_wr) |=> (tmr_value == $past(tmr_value) + ONE));

    p_single_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !tmr_wr |=> (tmr_value == $past(tmr_value) || tmr_value == $past(tmr_value) + ONE));

    p_flag_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !ovf_clr) |=> ovf_flag);

    p_wrap_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((!tmr_wr && tmr_value == TOPV) ##1 (tmr_value == ZRO)) |-> ovf_flag);

    p_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_timeout |=> !wdt_timeout);

    p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wdt_clr || sleep_stb) |=> !wdt_timeout);

    p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!wdt_en && $past(!wdt_en)) |-> !wdt_timeout);

endmodule

bind tmr_wdt_core tw_checker #(.TMR_W(TMR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .icyc_en     (icyc_en),
    .src_ext     (src_ext),
    .psc_to_wdt  (psc_to_wdt),
    .wdt_en      (wdt_en),
    .tmr_wr      (tmr_wr),
    .tmr_wdata   (tmr_wdata),
    .ovf_clr     (ovf_clr),
    .wdt_clr     (wdt_clr),
    .sleep_stb   (sleep_stb),
    .tmr_value   (tmr_value),
    .ovf_flag    (ovf_flag),
    .wdt_timeout (wdt_timeout)
);

// File: tb/sim_tmr_wdt_core.sv
module sim_tmr_wdt_core;

    localparam int WBW = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       icyc_en = 1'b0;
    logic       ext_pin = 1'b0;
    logic       src_ext = 1'b0;
    logic       edge_fall = 1'b0;
    logic       psc_to_wdt = 1'b1;
    logic [2:0] psc_ratio = 3'd0;
    logic       wdt_en = 1'b0;
    logic       tmr_wr = 1'b0;
    logic [7:0] tmr_wdata = 8'h00;
    logic       ovf_clr = 1'b0;
    logic       wdt_clr = 1'b0;
    logic       sleep_stb = 1'b0;
    logic [7:0] tmr_value;
    logic       ovf_flag;
    logic       wdt_timeout;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    tmr_wdt_core #(.WDT_BASE_W(WBW)) u0 (
        .clk(clk), .rst_n(rst_n), .icyc_en(icyc_en), .ext_pin(ext_pin),
        .src_ext(src_ext), .edge_fall(edge_fall), .psc_to_wdt(psc_to_wdt),
        .psc_ratio(psc_ratio), .wdt_en(wdt_en), .tmr_wr(tmr_wr),
        .tmr_wdata(tmr_wdata), .ovf_clr(ovf_clr), .wdt_clr(wdt_clr),
        .sleep_stb(sleep_stb), .tmr_value(tmr_value), .ovf_flag(ovf_flag),
        .wdt_timeout(wdt_timeout)
    );

    // scoreboard: sel 0 = timer value, 1 = flag, 2 = request, 3 = measured value
    typedef struct {
        int    sel;
        int    expv;
        int    actv;
        string req;
    } sb_item_t;

    sb_item_t sb_q[$];

    task automatic expect_port(input int sel, input int expv, input string req);
        sb_item_t it;
        it.sel = sel; it.expv = expv; it.actv = 0; it.req = req;
        sb_q.push_back(it);
    endtask

    task automatic expect_val(input int actv, input int expv, input string req);
        sb_item_t it;
        it.sel = 3; it.expv = expv; it.actv = actv; it.req = req;
        sb_q.push_back(it);
    endtask

    // monitor
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sb_q.size() > 0) begin
                sb_item_t it;
                int got;
                it = sb_q.pop_front();
                case (it.sel)
                    0:       got = int'(tmr_value);
                    1:       got = int'(ovf_flag);
                    2:       got = int'(wdt_timeout);
                    default: got = it.actv;
                endcase
                n_checks++;
                if (got != it.expv) begin
                    n_fail++;
                    $display("FAIL %s: got 0x%0h expected 0x%0h", it.req, got, it.expv);
                end
            end
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            icyc_en = 1'b1;
            @(negedge clk);
            icyc_en = 1'b0;
        end
    endtask

    task automatic wr_tmr(input logic [7:0] v);
        tmr_wr = 1'b1; tmr_wdata = v;
        @(negedge clk);
        tmr_wr = 1'b0;
    endtask

    task automatic wait_to(input int lim, output int k);
        k = 0;
        do begin
            @(negedge clk);
            k++;
        end while (!wdt_timeout && k < lim);
    endtask

    task automatic count_to(input int n, inout int hits);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (wdt_timeout) hits++;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run hung, got 0 expected 1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int k;
        int hits;
        cyc(3);
        expect_port(0, 0, "R1 value in reset");
        expect_port(1, 0, "R1 flag in reset");
        expect_port(2, 0, "R1 request in reset");
        rst_n = 1'b1;
        cyc(2);
        expect_port(0, 0, "R1 value after reset");

        // R3: 1:1 when the watchdog owns the prescaler
        tick(5);
        expect_port(0, 5, "R3 direct count");

        // R5 / R6: load, wrap, sticky flag
        wr_tmr(8'hFE);
        expect_port(0, 8'hFE, "R5 load");
        tick(1);
        expect_port(0, 8'hFF, "R6 pre wrap");
        expect_port(1, 0, "R6 flag before wrap");
        tick(1);
        expect_port(0, 0, "R6 wrap value");
        expect_port(1, 1, "R6 flag set");
        tick(1);
        cyc(3);
        expect_port(1, 1, "R6 flag sticky");
        ovf_clr = 1'b1; @(negedge clk); ovf_clr = 1'b0;
        expect_port(1, 0, "R6 flag cleared");

        // R6: set beats clear
        wr_tmr(8'hFF);
        icyc_en = 1'b1; ovf_clr = 1'b1;
        @(negedge clk);
        icyc_en = 1'b0; ovf_clr = 1'b0;
        expect_port(1, 1, "R6 set over clear");
        ovf_clr = 1'b1; @(negedge clk); ovf_clr = 1'b0;

        // R5: write beats count
        icyc_en = 1'b1; tmr_wr = 1'b1; tmr_wdata = 8'h40;
        @(negedge clk);
        icyc_en = 1'b0; tmr_wr = 1'b0;
        expect_port(0, 8'h40, "R5 write over count");

        // R2: ratios with the timer owning the prescaler
        psc_to_wdt = 1'b0;
        psc_ratio = 3'd0;
        wr_tmr(8'h00);
        tick(6);
        expect_port(0, 3, "R2 ratio 0");
        psc_ratio = 3'd2;
        wr_tmr(8'h00);
        tick(24);
        expect_port(0, 3, "R2 ratio 2 boundary");
        tick(7);
        expect_port(0, 3, "R2 ratio 2 below next");
        tick(1);
        expect_port(0, 4, "R2 ratio 2 next");
        psc_ratio = 3'd7;
        wr_tmr(8'h00);
        tick(512);
        expect_port(0, 2, "R2 ratio 7");

        // R5: write clears prescaler
        psc_ratio = 3'd1;
        wr_tmr(8'h00);
        tick(3);
        wr_tmr(8'h10);
        tick(3);
        expect_port(0, 8'h10, "R5 prescaler cleared by write");
        tick(1);
        expect_port(0, 8'h11, "R5 count after clear");

        // R7: sleep leaves the timer's prescaler alone
        wr_tmr(8'h00);
        tick(2);
        sleep_stb = 1'b1; @(negedge clk); sleep_stb = 1'b0;
        tick(2);
        expect_port(0, 1, "R7 sleep keeps prescaler");

        // R4: external source
        psc_to_wdt = 1'b1;
        src_ext = 1'b1;
        edge_fall = 1'b0;
        wr_tmr(8'h00);
        icyc_en = 1'b1;
        cyc(10);
        icyc_en = 1'b0;
        expect_port(0, 0, "R4 icyc ignored");
        for (int p = 0; p < 5; p++) begin
            ext_pin = 1'b1; cyc(8);
            ext_pin = 1'b0; cyc(8);
        end
        expect_port(0, 5, "R4 rising edges");
        ext_pin = 1'b1;
        cyc(2);
        expect_port(0, 5, "R4 edge not yet counted");
        cyc(1);
        expect_port(0, 6, "R4 edge at third clock");
        edge_fall = 1'b1;
        cyc(2);
        wr_tmr(8'h00);
        ext_pin = 1'b0; cyc(8);
        expect_port(0, 1, "R4 falling edge counted");
        ext_pin = 1'b1; cyc(8);
        expect_port(0, 1, "R4 rising ignored in falling mode");
        ext_pin = 1'b0; cyc(8);
        expect_port(0, 2, "R4 second falling edge");
        src_ext = 1'b0;
        edge_fall = 1'b0;

        // R8: watchdog periods
        psc_to_wdt = 1'b0;
        psc_ratio = 3'd0;
        wdt_en = 1'b1;
        wait_to(400, k);
        wait_to(400, k);
        expect_val(k, 1 << WBW, "R8 base period");
        cyc(1);
        expect_port(2, 0, "R8 single cycle pulse");
        psc_to_wdt = 1'b1;
        wait_to(400, k);
        wait_to(400, k);
        expect_val(k, 1 << (WBW + 1), "R8 period ratio 0");
        psc_ratio = 3'd1;
        wait_to(400, k);
        wait_to(400, k);
        expect_val(k, 1 << (WBW + 2), "R8 period ratio 1");

        // R9: restart by clear and by sleep
        cyc(5);
        wdt_clr = 1'b1; @(negedge clk); wdt_clr = 1'b0;
        wait_to(400, k);
        expect_val(k, 1 << (WBW + 2), "R9 period after clear");
        cyc(20);
        sleep_stb = 1'b1; @(negedge clk); sleep_stb = 1'b0;
        wait_to(400, k);
        expect_val(k, 1 << (WBW + 2), "R9 period after sleep");
        hits = 0;
        for (int r = 0; r < 6; r++) begin
            wdt_clr = 1'b1; @(negedge clk); wdt_clr = 1'b0;
            count_to(40, hits);
        end
        expect_val(hits, 0, "R9 regular clears hold off request");

        // R10: disabled watchdog stays quiet
        wdt_en = 1'b0;
        hits = 0;
        count_to(300, hits);
        expect_val(hits, 0, "R10 disabled no request");

        cyc(3);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule